// File: doc/BRIEF.md
# ISA Alternate Bus Master Handshake

This block lets a peripheral take over a 16-bit ISA-style expansion bus and run its own memory cycles. When internal logic presents a transfer descriptor, the block raises the DMA request line of one of four selectable channels. It waits for the host's acknowledge to be held low, then asserts MASTER and starts driving address, SBHE and the memory strobes itself, so it acts as a full alternate master rather than relying on addresses from the system DMA controller.

Each memory cycle holds its strobe for a programmable minimum number of clocks before the ready line is looked at, and then stretches for as long as ready is sampled low. The block hands the bus back when no descriptor is pending or when a burst limit is reached. It first floats its drivers and then drops the request. It will not request again until the acknowledge line has gone high. On the internal side a descriptor is a level request with address, direction and write data. It is accepted with a one-clock pulse and completed with a second pulse that carries read data.

Top module: `isa_altmaster`

## Requirements
- R1: While reset is held, `drq` is 0, `drv_oe` and `data_oe` are 0, `master_n`, `memr_n` and `memw_n` are 1, and `xfer_ack` and `xfer_done` are 0.
- R2: `chan_sel` values 0, 1, 2 and 3 select the channel pairs 3, 5, 6 and 7. These are carried on bit 0, 1, 2 and 3 of `drq` and `dack_n`. Only the selected `drq` bit is ever raised.
- R3: `drv_oe` rises and `master_n` falls only after the selected `dack_n` has been sampled low on two consecutive clock edges. A single-clock low pulse on `dack_n` does not start bus ownership.
- R4: During every strobe `drv_oe` is 1, `sbhe_n` is 0 and `mem_addr` equals the `xfer_addr` of the descriptor being executed.
- R5: A strobe stays low for exactly max(`cfg_strobe_clks`,1) + 1 + k clocks. Here k is the number of consecutive low samples of `iochrdy` taken after the minimum. The state of `iochrdy` during the minimum is ignored.
- R6: A read cycle drives only `memr_n` with `data_oe` at 0, and returns `data_in` on `xfer_rdata` with `xfer_done`. A write cycle drives only `memw_n`, with `data_oe` at 1 and `data_out` equal to the descriptor's write data.
- R7: At most BURST_MAX descriptors are accepted per bus ownership. If more remain, the bus is released and requested again.
- R8: On release, `drv_oe` is 0 for at least one clock before the `drq` bit falls.
- R9: After a release, `drq` is not raised again while the selected `dack_n` is still low.
- R10: `xfer_ack` pulses once for each accepted descriptor, and `xfer_done` pulses once for each completed cycle, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_sel | input | 2 | Channel pick: 0..3 select channels 3, 5, 6, 7 |
| cfg_strobe_clks | input | SW | Minimum strobe clocks before ready is sampled |
| xfer_req | input | 1 | A descriptor is pending |
| xfer_wr | input | 1 | Descriptor direction, 1 = write |
| xfer_addr | input | AW | Descriptor memory address |
| xfer_wdata | input | DW | Descriptor write data |
| xfer_ack | output | 1 | Descriptor accepted (one clock) |
| xfer_done | output | 1 | Cycle completed (one clock) |
| xfer_rdata | output | DW | Read data, valid with xfer_done |
| drq | output | 4 | DMA request lines, channels 3, 5, 6, 7 |
| dack_n | input | 4 | DMA acknowledge lines, active low |
| drv_oe | output | 1 | Enable for MASTER, address, SBHE and strobe drivers |
| master_n | output | 1 | MASTER, active low |
| mem_addr | output | AW | Bus address |
| sbhe_n | output | 1 | Byte high enable, active low |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| data_oe | output | 1 | Data bus driver enable |
| data_out | output | DW | Data driven on writes |
| data_in | input | DW | Data sampled on reads |
| iochrdy | input | 1 | Channel ready, low extends the cycle |

## Verification
The bench goes after five corner cases.

- A one-clock acknowledge glitch. A block that took the bus on a single low sample would assert MASTER while the acknowledge is already high again.
- Ready driven high during the strobe minimum, or held low for several clocks after it. A block that samples ready too early ends the strobe short; one that ignores it ends the strobe long.
- Descriptor counts above the burst limit. A missing limit shows as too few grants.
- Drivers dropping only together with the request, or a new request while the acknowledge is still low. Either breaks the release ordering.
- A zero strobe setting. This must behave like one clock and not wrap the counter.

// File: rtl/isa_altm_pkg.sv
package isa_altm_pkg;
   localparam int NUM_CH = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_WACK,
      ST_OWN,
      ST_CYC,
      ST_WRDY,
      ST_REL
   } altm_state_e;
endpackage

// File: rtl/isa_altm_chan.sv
module isa_altm_chan #(
   parameter int NCH  = 4,
   localparam int SELW = $clog2(NCH)
) (
   input  logic [SELW-1:0] sel,
   input  logic            req,
   input  logic [NCH-1:0]  dack_n,
   output logic [NCH-1:0]  drq,
   output logic            dack_sel_n
);
   for (genvar gi = 0; gi < NCH; gi++) begin : g_line
      assign drq[gi] = req && (sel == SELW'(gi));
   end

   assign dack_sel_n = dack_n[sel];
endmodule

// File: rtl/isa_altm_timer.sv
module isa_altm_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         en,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= load_val;
      else if (en && cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/isa_altm_burst.sv
module isa_altm_burst #(
   parameter int BURST_MAX = 8,
   localparam int CW = $clog2(BURST_MAX + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic inc,
   output logic full
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else if (inc)   cnt <= cnt + 1'b1;
   end

   assign full = (cnt == CW'(BURST_MAX));
endmodule

// File: rtl/isa_altmaster.sv
module isa_altmaster
   import isa_altm_pkg::*;
#(
   parameter int AW        = 24,
   parameter int DW        = 16,
   parameter int SW        = 4,
   parameter int BURST_MAX = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                chan_sel,
   input  logic [SW-1:0]             cfg_strobe_clks,
   input  logic                      xfer_req,
   input  logic                      xfer_wr,
   input  logic [AW-1:0]             xfer_addr,
   input  logic [DW-1:0]             xfer_wdata,
   output logic                      xfer_ack,
   output logic                      xfer_done,
   output logic [DW-1:0]             xfer_rdata,
   output logic [3:0]                drq,
   input  logic [3:0]                dack_n,
   output logic                      drv_oe,
   output logic                      master_n,
   output logic [AW-1:0]             mem_addr,
   output logic                      sbhe_n,
   output logic                      memr_n,
   output logic                      memw_n,
   output logic                      data_oe,
   output logic [DW-1:0]             data_out,
   input  logic [DW-1:0]             data_in,
   input  logic                      iochrdy
);
   localparam int SELW = $clog2(NUM_CH);

   if (DW != 16) begin : g_bad_dw
      $error("alternate master must be a 16-bit device");
   end
   if (BURST_MAX < 1) begin : g_bad_burst
      $error("BURST_MAX must be at least 1");
   end
   if (SW < 1 || AW < 1) begin : g_bad_width
      $error("SW and AW must be positive");
   end

   altm_state_e        state, state_nx;
   logic [SELW-1:0]    chan_q;
   logic [SELW-1:0]    chan_use;
   logic               wr_q;
   logic [AW-1:0]      addr_q;
   logic [DW-1:0]      wdata_q;
   logic               dack_sel_n;
   logic               req_line;
   logic               take;
   logic               cyc_end;
   logic               burst_full;
   logic               min_done;
   logic [SW-1:0]      min_load;
   logic               strobing;

   assign chan_use = (state == ST_IDLE) ? chan_sel : chan_q;
   assign req_line = (state != ST_IDLE);

   isa_altm_chan #(.NCH(NUM_CH)) u_chan (
      .sel        (chan_use),
      .req        (req_line),
      .dack_n     (dack_n),
      .drq        (drq),
      .dack_sel_n (dack_sel_n)
   );

   assign take     = (state == ST_OWN) && xfer_req && !burst_full;
   assign cyc_end  = (state == ST_WRDY) && iochrdy;
   assign min_load = (cfg_strobe_clks == '0) ? '0 : cfg_strobe_clks - 1'b1;

   isa_altm_timer #(.W(SW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (take),
      .load_val (min_load),
      .en       (state == ST_CYC),
      .expired  (min_done)
   );

   isa_altm_burst #(.BURST_MAX(BURST_MAX)) u_burst (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state == ST_IDLE),
      .inc   (take),
      .full  (burst_full)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: if (xfer_req && dack_sel_n)  state_nx = ST_REQ;
         ST_REQ:  if (!dack_sel_n)             state_nx = ST_WACK;
         ST_WACK: state_nx = dack_sel_n ? ST_REQ : ST_OWN;
         ST_OWN:  state_nx = take ? ST_CYC : ST_REL;
         ST_CYC:  if (min_done)                state_nx = ST_WRDY;
         ST_WRDY: if (iochrdy)                 state_nx = ST_OWN;
         ST_REL:  state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         chan_q     <= '0;
         wr_q       <= 1'b0;
         addr_q     <= '0;
         wdata_q    <= '0;
         xfer_ack   <= 1'b0;
         xfer_done  <= 1'b0;
         xfer_rdata <= '0;
      end else begin
         state     <= state_nx;
         xfer_ack  <= take;
         xfer_done <= cyc_end;
         if (state == ST_IDLE) chan_q <= chan_sel;
         if (take) begin
            wr_q    <= xfer_wr;
            addr_q  <= xfer_addr;
            wdata_q <= xfer_wdata;
         end
         if (cyc_end && !wr_q) xfer_rdata <= data_in;
      end
   end

   assign strobing = (state == ST_CYC) || (state == ST_WRDY);
   assign drv_oe   = (state == ST_OWN) || strobing;
   assign master_n = !drv_oe;
   assign sbhe_n   = !drv_oe;
   assign memr_n   = !(strobing && !wr_q);
   assign memw_n   = !(strobing && wr_q);
   assign data_oe  = strobing && wr_q;
   assign mem_addr = addr_q;
   assign data_out = wdata_q;
endmodule

// File: rtl/isa_altmaster_chk.sv
module isa_altmaster_chk #(
   parameter int BURST_MAX = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] drq,
   input logic [3:0] dack_n,
   input logic       drv_oe,
   input logic       master_n,
   input logic       memr_n,
   input logic       memw_n,
   input logic       sbhe_n,
   input logic       xfer_ack
);
   logic [15:0] own_acks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        own_acks <= '0;
      else if (!drv_oe)  own_acks <= '0;
      else if (xfer_ack) own_acks <= own_acks + 1'b1;
   end

   AST_DRQ_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drq)); // R2

   AST_OWN_AFTER_DACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_oe) |-> (((drq & ~dack_n) != 4'b0) && $past((drq & ~dack_n) != 4'b0))); // R3

   AST_STROBE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!memr_n || !memw_n) |-> (drv_oe && !sbhe_n && !master_n)); // R4

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!memr_n && !memw_n)); // R6

   AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      own_acks <= 16'(BURST_MAX)); // R7

   AST_FLOAT_BEFORE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(|drq) |-> $past(!drv_oe)); // R8

   AST_NO_EARLY_REREQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|drq) |-> ((drq & ~dack_n) == 4'b0)); // R9
endmodule

bind isa_altmaster isa_altmaster_chk #(.BURST_MAX(BURST_MAX)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .drq      (drq),
   .dack_n   (dack_n),
   .drv_oe   (drv_oe),
   .master_n (master_n),
   .memr_n   (memr_n),
   .memw_n   (memw_n),
   .sbhe_n   (sbhe_n),
   .xfer_ack (xfer_ack)
);

// File: tb/test_isa_altmaster.sv
module test_isa_altmaster;
   localparam int AW = 24;
   localparam int DW = 16;
   localparam int SW = 4;
   localparam int BURST = 3;

   typedef struct packed {
      logic [1:0] chan;
      logic [3:0] cfg;
      logic [3:0] wt;
      logic [3:0] n;
      logic       wr;
      logic [3:0] rel;
      logic       gl;
      logic [4:0] estr;
      logic [2:0] egr;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 4'd2, 4'd0, 4'd2, 1'b0, 4'd1, 1'b0, 5'd3, 3'd1},
      '{2'd1, 4'd0, 4'd3, 4'd3, 1'b1, 4'd6, 1'b0, 5'd5, 3'd1},
      '{2'd2, 4'd5, 4'd1, 4'd4, 1'b0, 4'd2, 1'b0, 5'd7, 3'd2},
      '{2'd3, 4'd1, 4'd2, 4'd7, 1'b1, 4'd6, 1'b0, 5'd4, 3'd3},
      '{2'd0, 4'd3, 4'd4, 4'd1, 1'b1, 4'd1, 1'b0, 5'd8, 3'd1},
      '{2'd3, 4'd0, 4'd0, 4'd3, 1'b0, 4'd3, 1'b0, 5'd2, 3'd1},
      '{2'd1, 4'd1, 4'd0, 4'd2, 1'b1, 4'd2, 1'b1, 5'd2, 3'd1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    chan_sel = '0;
   logic [SW-1:0] cfg_strobe_clks = '0;
   logic          xfer_req = 1'b0;
   logic          xfer_wr = 1'b0;
   logic [AW-1:0] xfer_addr = '0;
   logic [DW-1:0] xfer_wdata = '0;
   logic          xfer_ack;
   logic          xfer_done;
   logic [DW-1:0] xfer_rdata;
   logic [3:0]    drq;
   logic [3:0]    dack_n = 4'hF;
   logic          drv_oe;
   logic          master_n;
   logic [AW-1:0] mem_addr;
   logic          sbhe_n;
   logic          memr_n;
   logic          memw_n;
   logic          data_oe;
   logic [DW-1:0] data_out;
   logic [DW-1:0] data_in;
   logic          iochrdy = 1'b1;

   int nchk = 0;
   int nfail = 0;

   always #4 clk = ~clk;

   assign data_in = mem_addr[15:0] ^ 16'h5A3C;

   isa_altmaster #(.AW(AW), .DW(DW), .SW(SW), .BURST_MAX(BURST)) i_isa_altmaster (
      .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .cfg_strobe_clks(cfg_strobe_clks),
      .xfer_req(xfer_req), .xfer_wr(xfer_wr), .xfer_addr(xfer_addr), .xfer_wdata(xfer_wdata),
      .xfer_ack(xfer_ack), .xfer_done(xfer_done), .xfer_rdata(xfer_rdata),
      .drq(drq), .dack_n(dack_n), .drv_oe(drv_oe), .master_n(master_n),
      .mem_addr(mem_addr), .sbhe_n(sbhe_n), .memr_n(memr_n), .memw_n(memw_n),
      .data_oe(data_oe), .data_out(data_out), .data_in(data_in), .iochrdy(iochrdy)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] wpat(input logic [AW-1:0] a);
      return a[15:0] ^ 16'h1234;
   endfunction

   task automatic run_vector(input vec_t v, input logic [AW-1:0] base);
      int c = int'(v.chan);
      int nmin = (v.cfg == 0) ? 1 : int'(v.cfg);
      int k = int'(v.wt);
      int n = int'(v.n);
      int idx = 0, dn = 0, grants = 0, sc = 0, own_acks = 0, guard = 0;
      int dk [4] = '{0, 0, 0, 0};
      int rl [4] = '{0, 0, 0, 0};
      logic [3:0] p_drq = drq;
      logic p_oe = drv_oe, p_act = 1'b0, p_dack = 1'b1, act;
      logic [AW-1:0] a;

      chan_sel        = v.chan;
      cfg_strobe_clks = v.cfg;
      xfer_wr         = v.wr;
      xfer_req        = (n > 0);
      xfer_addr       = base;
      xfer_wdata      = wpat(base);
      forever begin
         @(negedge clk);
         guard++;
         act = !memr_n || !memw_n;
         if ((drq & ~p_drq) != 4'b0) begin
            chk(drq == (4'b1 << c), "R2", drq, 4'b1 << c);
            chk(dack_n[c] == 1'b1, "R9", dack_n[c], 1);
         end
         if (drv_oe && !p_oe) begin
            grants++;
            own_acks = 0;
            chk(!dack_n[c] && !p_dack, "R3", {p_dack, dack_n[c]}, 0);
            chk(!master_n, "R3", master_n, 0);
         end
         if (!drq[c] && p_drq[c]) chk(!p_oe, "R8", p_oe, 0);
         if (act) begin
            sc++;
            if (sc == 1) begin
               a = base + AW'(2 * idx);
               chk(mem_addr == a, "R4", mem_addr, a);
               chk(!sbhe_n && drv_oe, "R4", {drv_oe, sbhe_n}, 2);
               if (v.wr) chk(!memw_n && memr_n && data_oe && data_out == wpat(a), "R6",
                             data_out, wpat(a));
               else      chk(!memr_n && memw_n && !data_oe, "R6", {memr_n, memw_n, data_oe}, 2);
            end
         end else if (p_act) begin
            chk(sc == int'(v.estr), "R5", sc, v.estr);
            sc = 0;
         end
         if (xfer_done) begin
            a = base + AW'(2 * dn);
            if (!v.wr) chk(xfer_rdata == (a[15:0] ^ 16'h5A3C), "R6", xfer_rdata, a[15:0] ^ 16'h5A3C);
            dn++;
         end
         if (xfer_ack) begin
            idx++;
            own_acks++;
            chk(own_acks <= BURST, "R7", own_acks, BURST);
         end
         iochrdy = !(act && sc > nmin && sc <= nmin + k);
         for (int i = 0; i < 4; i++) begin
            if (drq[i]) begin
               rl[i] = 0;
               dk[i]++;
               if (v.gl) dack_n[i] = !(dk[i] == 2 || dk[i] >= 6);
               else if (dk[i] >= 2) dack_n[i] = 1'b0;
            end else begin
               dk[i] = 0;
               if (!dack_n[i]) begin
                  rl[i]++;
                  if (rl[i] >= int'(v.rel)) dack_n[i] = 1'b1;
               end
            end
         end
         xfer_req   = (idx < n);
         xfer_addr  = base + AW'(2 * idx);
         xfer_wdata = wpat(base + AW'(2 * idx));
         p_drq  = drq;
         p_oe   = drv_oe;
         p_act  = act;
         p_dack = dack_n[c];
         if ((dn == n && drq == 4'b0 && !drv_oe && dack_n == 4'hF) || guard > 2000) break;
      end
      chk(grants == int'(v.egr), "R7", grants, v.egr);
      chk(dn == n, "R10", dn, n);
      chk(idx == n, "R10", idx, n);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(drq == 4'b0, "R1", drq, 0);
      chk(!drv_oe && !data_oe, "R1", {drv_oe, data_oe}, 0);
      chk(master_n && memr_n && memw_n, "R1", {master_n, memr_n, memw_n}, 7);
      chk(!xfer_ack && !xfer_done, "R1", {xfer_ack, xfer_done}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(drq == 4'b0 && !drv_oe, "R1", {drq, drv_oe}, 0);

      for (int vi = 0; vi < NV; vi++) begin
         run_vector(VECS[vi], AW'(24'h010100 + vi * 24'h010000));
         repeat (3) @(negedge clk);
      end

      // R9: descriptor pending while acknowledge still low must not request
      chan_sel = 2'd2;
      dack_n   = 4'b1011;
      xfer_req = 1'b1;
      xfer_wr  = 1'b0;
      repeat (6) @(negedge clk);
      chk(drq == 4'b0, "R9", drq, 0);
      chk(!drv_oe, "R9", drv_oe, 0);
      xfer_req = 1'b0;
      dack_n   = 4'hF;
      repeat (3) @(negedge clk);
      chk(drq == 4'b0, "R2", drq, 0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule